// File: doc/BRIEF.md
# MSK Transmit Byte Framer

This block turns host bytes into a continuous-phase MSK tone sequence. The host writes one byte at a time into a single holding register. The framer moves each byte into a shift register and sends it MSB first at either 1200 or 2400 baud. The output is a tone code together with a phase-accumulator sample that a sine lookup or DAC stage further down the chain can use.

Preamble and frame-sync patterns carry no special meaning here. The host writes them like any other data byte. A checksum-enable input marks a run of whole bytes. When that input is released, the framer finishes the byte in flight and then sends the two CRC bytes on its own. When no further data is waiting, one trailing hang bit is sent and the framer goes idle with the phase at zero.

The framer is controlled by a state machine with five states:
- **IDLE**: waits for a byte or a pending checksum.
- **DATA**: sends a host byte.
- **SUM_HI**: sends the checksum high byte.
- **SUM_LO**: sends the checksum low byte.
- **HANG**: sends the single hang bit.

The transitions are:
- IDLE→SUM_HI when a checksum is pending; otherwise IDLE→DATA when the buffer is full.
- At the end of a DATA byte, the next state is SUM_HI if a checksum is pending. Otherwise it is DATA if the buffer is full, or HANG if it is not.
- SUM_HI→SUM_LO at the end of the byte.
- At the end of SUM_LO, the next state is DATA if the buffer is full, or HANG if it is not.
- HANG→IDLE after one bit.
- Any state→IDLE when transmission is not permitted.

Top module: `msk_tx_framer`

## Requirements
- R1: After reset, `busy`=0, `buf_empty`=1, `phase_out`=0 and `tone_sel`=0.
- R2: Bytes go out in write order, MSB first. Each bit lasts CLK_DIV*SPB clocks when `rate_sel`=0 (1200 baud) and CLK_DIV*SPB/2 clocks when `rate_sel`=1 (2400 baud). `rate_sel` is sampled at the start of each bit. `bit_done` pulses for one clock at the end of every bit, while `tx_bit` still shows that bit.
- R3: `tone_sel` encodes the tone as follows. Code 1 (1200 Hz) is used for a 1 bit at either rate. Code 2 (1800 Hz) is used for a 0 bit at 1200 baud. Code 3 (2400 Hz) is used for a 0 bit at 2400 baud. The code is 0 when idle, and it stays constant within a bit.
- R4: `phase_out` advances by the following amounts over each bit, with no jump at bit boundaries. The unit is one full turn, 2^PHASE_W.
  - At 1200 baud, a 1 bit advances 1 turn and a 0 bit advances 1.5 turns.
  - At 2400 baud, a 1 bit advances 0.5 turn and a 0 bit advances 1 turn.
- R5: `buf_empty` is 1 whenever the holding register can take a byte. A write while it is 0 is ignored. The flag rises when the held byte starts transmission.
- R6: A rising edge of `sum_en` clears the CRC to 0. Every byte that starts while checksumming is on is folded in. The CRC is CRC-16 with polynomial 0x1021, processed MSB first.
- R7: On the falling edge of `sum_en`, the byte in flight completes. The CRC is then sent as the next two bytes, high byte first, before any further data byte.
- R8: Once the last byte has gone and the buffer is empty, one hang bit of value 1 is sent. After that, `busy` drops and `phase_out` returns to 0 one clock later.
- R9: Transmission is permitted only when `tx_en`=1, `rx_en`=0 and `tone_en`=0. When that condition does not hold, `busy` falls after one clock and the buffer is emptied. Writes are ignored while it does not hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable; set together with tx_en, it forces idle |
| tone_en | input | 1 | Dual-tone generator enable; set together with tx_en, it forces idle |
| rate_sel | input | 1 | 0 = 1200 baud, 1 = 2400 baud |
| sum_en | input | 1 | Checksum region enable |
| wr_valid | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Host byte |
| buf_empty | output | 1 | Holding register can accept a byte |
| busy | output | 1 | State machine not idle |
| tx_bit | output | 1 | Bit currently being sent |
| bit_done | output | 1 | One-clock pulse at the end of each bit |
| tone_sel | output | 2 | Tone code: 0 off, 1 = 1200 Hz, 2 = 1800 Hz, 3 = 2400 Hz |
| phase_out | output | PHASE_W | Phase-accumulator sample |

## Verification
A wrong state transition shows up as a byte that is missing, duplicated or reordered in the recovered bit stream. It can also show up as two checksum bytes that do not match a CRC computed independently over the bracketed bytes. Either fault appears no later than the end of the frame. A wrong step or rate latch shows up sooner: the phase compared at the very next bit boundary is off, or the spacing between two `bit_done` pulses is wrong. A fault in the buffer or the enable gating shows on `buf_empty` and `busy` within one or two clocks of the triggering write or enable change.

// File: rtl/msk_tx_pkg.sv
package msk_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_SUM_HI,
        ST_SUM_LO,
        ST_HANG
    } tx_state_t;

    localparam logic [1:0] TONE_OFF   = 2'd0;
    localparam logic [1:0] TONE_MARK  = 2'd1;
    localparam logic [1:0] TONE_SLOW0 = 2'd2;
    localparam logic [1:0] TONE_FAST0 = 2'd3;

endpackage

// File: rtl/msk_bit_timer.sv
module msk_bit_timer #(
    parameter int CLK_DIV = 2,
    parameter int SPB     = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    output logic tick,
    output logic bit_end
);
    localparam int DW = $clog2(CLK_DIV + 1);
    localparam int SW = $clog2(SPB);

    logic [DW-1:0] div_q;
    logic [SW-1:0] smp_q;
    logic [SW-1:0] smp_last;

    assign tick     = run && (div_q == DW'(CLK_DIV - 1));
    assign smp_last = fast ? SW'(SPB / 2 - 1) : SW'(SPB - 1);
    assign bit_end  = tick && (smp_q == smp_last);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
            smp_q <= '0;
        end else begin
            div_q <= tick ? '0 : div_q + DW'(1);
            if (tick) begin
                smp_q <= bit_end ? '0 : smp_q + SW'(1);
            end
        end
    end

endmodule

// File: rtl/msk_phase_nco.sv
module msk_phase_nco
    import msk_tx_pkg::*;
#(
    parameter int PHASE_W = 8,
    parameter int SPB     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               tick,
    input  logic               bit_val,
    input  logic               fast,
    output logic [1:0]         tone,
    output logic [PHASE_W-1:0] phase
);
    localparam int MARK_INC = (1 << PHASE_W) / SPB;
    localparam logic [PHASE_W-1:0] STEP_MARK  = PHASE_W'(MARK_INC);
    localparam logic [PHASE_W-1:0] STEP_SLOW0 = PHASE_W'(MARK_INC * 3 / 2);
    localparam logic [PHASE_W-1:0] STEP_FAST0 = PHASE_W'(MARK_INC * 2);

    logic [PHASE_W-1:0] step;

    always_comb begin
        if (!run)         tone = TONE_OFF;
        else if (bit_val) tone = TONE_MARK;
        else if (fast)    tone = TONE_FAST0;
        else              tone = TONE_SLOW0;
    end

    always_comb begin
        unique case (tone)
            TONE_MARK:  step = STEP_MARK;
            TONE_SLOW0: step = STEP_SLOW0;
            TONE_FAST0: step = STEP_FAST0;
            default:    step = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) phase <= '0;
        else if (tick)      phase <= phase + step;
    end

endmodule

// File: rtl/msk_crc16.sv
module msk_crc16 #(
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        shift,
    input  logic        din,
    output logic [15:0] crc_next
);
    logic [15:0] crc_q;
    logic        fb;

    assign fb = crc_q[15] ^ din;

    always_comb begin
        if (clr)        crc_next = '0;
        else if (shift) crc_next = {crc_q[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
        else            crc_next = crc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_next;
    end

endmodule

// File: rtl/msk_tx_framer.sv
module msk_tx_framer
    import msk_tx_pkg::*;
#(
    parameter int          CLK_DIV  = 2,
    parameter int          SPB      = 16,
    parameter int          PHASE_W  = 8,
    parameter logic [15:0] CRC_POLY = 16'h1021,
    parameter logic        HANG_VAL = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic               rx_en,
    input  logic               tone_en,
    input  logic               rate_sel,
    input  logic               sum_en,
    input  logic               wr_valid,
    input  logic [7:0]         wr_data,
    output logic               buf_empty,
    output logic               busy,
    output logic               tx_bit,
    output logic               bit_done,
    output logic [1:0]         tone_sel,
    output logic [PHASE_W-1:0] phase_out
);
    tx_state_t   st_q, st_d;
    logic        tx_ok;
    logic [7:0]  buf_q, sh_q, byte_val;
    logic        buf_full_q;
    logic [2:0]  idx_q;
    logic        rate_q;
    logic        sum_en_q, sum_run_q, sum_pend_q, byte_in_q;
    logic        sum_rise, sum_fall, sum_run_d, pend_now;
    logic        tick, bit_end, byte_done;
    logic        start_byte, load_data, enter_hang, enter_sum;
    logic [15:0] crc_d;

    assign tx_ok     = tx_en && !rx_en && !tone_en;
    assign sum_rise  = tx_ok && sum_en && !sum_en_q;
    assign sum_fall  = !sum_en && sum_en_q;
    assign sum_run_d = tx_ok && ((sum_run_q && !sum_fall) || sum_rise);
    assign pend_now  = sum_pend_q || (sum_fall && sum_run_q);
    assign byte_done = bit_end && (idx_q == 3'd7)
                       && (st_q inside {ST_DATA, ST_SUM_HI, ST_SUM_LO});

    msk_bit_timer #(.CLK_DIV(CLK_DIV), .SPB(SPB)) timer_i (
        .clk(clk), .rst_n(rst_n), .run(busy), .fast(rate_q),
        .tick(tick), .bit_end(bit_end)
    );

    msk_phase_nco #(.PHASE_W(PHASE_W), .SPB(SPB)) nco_i (
        .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick),
        .bit_val(sh_q[7]), .fast(rate_q), .tone(tone_sel), .phase(phase_out)
    );

    msk_crc16 #(.POLY(CRC_POLY)) crc_i (
        .clk(clk), .rst_n(rst_n), .clr(sum_rise),
        .shift(bit_end && (st_q == ST_DATA) && byte_in_q),
        .din(sh_q[7]), .crc_next(crc_d)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (!tx_ok) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (pend_now)        st_d = ST_SUM_HI;
                    else if (buf_full_q) st_d = ST_DATA;
                end
                ST_DATA: begin
                    if (byte_done) begin
                        if (pend_now)        st_d = ST_SUM_HI;
                        else if (buf_full_q) st_d = ST_DATA;
                        else                 st_d = ST_HANG;
                    end
                end
                ST_SUM_HI: if (byte_done) st_d = ST_SUM_LO;
                ST_SUM_LO: begin
                    if (byte_done) st_d = buf_full_q ? ST_DATA : ST_HANG;
                end
                ST_HANG: if (bit_end) st_d = ST_IDLE;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    assign start_byte = (st_d inside {ST_DATA, ST_SUM_HI, ST_SUM_LO})
                        && ((st_q == ST_IDLE) || byte_done);
    assign load_data  = start_byte && (st_d == ST_DATA);
    assign enter_hang = (st_d == ST_HANG) && (st_q != ST_HANG);
    assign enter_sum  = (st_d == ST_SUM_HI) && (st_q != ST_SUM_HI);

    always_comb begin
        unique case (st_d)
            ST_SUM_HI: byte_val = crc_d[15:8];
            ST_SUM_LO: byte_val = crc_d[7:0];
            default:   byte_val = buf_q;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q      <= '0;
            buf_full_q <= 1'b0;
            sh_q       <= '0;
            idx_q      <= '0;
            rate_q     <= 1'b0;
            sum_en_q   <= 1'b0;
            sum_run_q  <= 1'b0;
            sum_pend_q <= 1'b0;
            byte_in_q  <= 1'b0;
        end else begin
            sum_en_q  <= sum_en;
            sum_run_q <= sum_run_d;

            if (!tx_ok)                      sum_pend_q <= 1'b0;
            else if (enter_sum)              sum_pend_q <= 1'b0;
            else if (sum_fall && sum_run_q)  sum_pend_q <= 1'b1;

            if (!tx_ok || load_data) begin
                buf_full_q <= 1'b0;
            end else if (wr_valid && !buf_full_q) begin
                buf_q      <= wr_data;
                buf_full_q <= 1'b1;
            end

            if (start_byte) begin
                sh_q      <= byte_val;
                idx_q     <= '0;
                rate_q    <= rate_sel;
                byte_in_q <= load_data && sum_run_d;
            end else if (enter_hang) begin
                sh_q   <= {HANG_VAL, 7'b0};
                rate_q <= rate_sel;
            end else if (bit_end) begin
                sh_q   <= {sh_q[6:0], 1'b0};
                idx_q  <= idx_q + 3'd1;
                rate_q <= rate_sel;
            end
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign buf_empty = !buf_full_q;
    assign tx_bit    = sh_q[7];
    assign bit_done  = bit_end;

endmodule

// File: rtl/msk_tx_framer_chk.sv
module msk_tx_framer_chk #(
    parameter int PHASE_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tx_en,
    input logic               rx_en,
    input logic               tone_en,
    input logic               busy,
    input logic               bit_done,
    input logic [1:0]         tone_sel,
    input logic [PHASE_W-1:0] phase_out
);
    assert_idle_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && rx_en) |=> !busy);

    assert_idle_tone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tone_en) |=> !busy);

    assert_phase_home_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> (phase_out == '0));

    assert_tone_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tone_sel == 2'd0));

    assert_tone_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(bit_done)) |-> $stable(tone_sel));

    assert_bit_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done |=> !bit_done);

endmodule

bind msk_tx_framer msk_tx_framer_chk #(.PHASE_W(PHASE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .tone_en(tone_en),
    .busy(busy), .bit_done(bit_done), .tone_sel(tone_sel), .phase_out(phase_out)
);

// File: tb/msk_tx_framer_tb.sv
module msk_tx_framer_tb_top;
    localparam int DIV = 2;
    localparam int SPB = 16;
    localparam int PW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0, rx_en = 1'b0, tone_en = 1'b0, rate_sel = 1'b0, sum_en = 1'b0;
    logic wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic buf_empty, busy, tx_bit, bit_done;
    logic [1:0] tone_sel;
    logic [PW-1:0] phase_out;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    msk_tx_framer #(.CLK_DIV(DIV), .SPB(SPB), .PHASE_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .tone_en(tone_en),
        .rate_sel(rate_sel), .sum_en(sum_en), .wr_valid(wr_valid), .wr_data(wr_data),
        .buf_empty(buf_empty), .busy(busy), .tx_bit(tx_bit), .bit_done(bit_done),
        .tone_sel(tone_sel), .phase_out(phase_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_add(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c ^ {b, 8'h00};
        for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    function automatic logic [PW-1:0] advance(input logic b, input logic fast);
        int halves = fast ? (b ? 1 : 2) : (b ? 2 : 3);
        return PW'(halves * (1 << (PW - 1)));
    endfunction

    // bit stream monitor
    logic rec [0:1023];
    int   nrec = 0;
    logic frame_rate = 1'b0;
    logic [PW-1:0] model_ph = '0;
    bit   ph_pending = 0;
    int   cyc = 0, last_done = 0;
    bit   have_last = 0;

    always @(negedge clk) begin
        cyc++;
        if (!busy) begin
            model_ph  = '0;
            have_last = 0;
        end
        if (ph_pending && busy)
            chk(phase_out == model_ph, "R4 phase at bit boundary", phase_out, model_ph);
        ph_pending = 0;
        if (rst_n && bit_done) begin
            if (nrec < 1024) rec[nrec] = tx_bit;
            nrec++;
            chk(tone_sel == (tx_bit ? 2'd1 : (frame_rate ? 2'd3 : 2'd2)),
                "R3 tone code", tone_sel, tx_bit ? 1 : (frame_rate ? 3 : 2));
            if (have_last)
                chk(cyc - last_done == (frame_rate ? DIV * SPB / 2 : DIV * SPB),
                    "R2 bit duration", cyc - last_done,
                    frame_rate ? DIV * SPB / 2 : DIV * SPB);
            last_done  = cyc;
            have_last  = 1;
            model_ph   = model_ph + advance(tx_bit, frame_rate);
            ph_pending = 1;
        end
    end

    task automatic wait_empty();
        while (!buf_empty) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b);
        wr_valid = 1'b1;
        wr_data  = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_frame_end();
        while (!busy) @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    logic [7:0] ex [0:31];
    bit         ex_sum [0:31];
    int         nex;

    task automatic compare_stream();
        chk(nrec == 8 * nex + 1, "R2 bit count", nrec, 8 * nex + 1);
        if (nrec == 8 * nex + 1) begin
            for (int j = 0; j < nex; j++) begin
                logic [7:0] got = '0;
                for (int k = 0; k < 8; k++) got = {got[6:0], rec[8 * j + k]};
                chk(got == ex[j], ex_sum[j] ? "R6 R7 checksum byte" : "R2 data byte",
                    got, ex[j]);
            end
            chk(rec[8 * nex] == 1'b1, "R8 hang bit", rec[8 * nex], 1);
        end
        @(negedge clk);
        chk(phase_out == '0, "R8 phase home", phase_out, 0);
        chk(buf_empty == 1'b1, "R5 empty at end", buf_empty, 1);
    endtask

    task automatic run_frame(input int npre, input int nsum, input int npost, input logic rate);
        logic [7:0]  wb [0:31];
        logic [15:0] c = '0;
        int nw = npre + nsum + npost;
        nex = 0;
        for (int i = 0; i < nw; i++) wb[i] = 8'($urandom);
        for (int i = 0; i < npre + nsum; i++) begin
            if (i >= npre) c = crc_add(c, wb[i]);
            ex[nex] = wb[i]; ex_sum[nex] = 0; nex++;
        end
        if (nsum > 0) begin
            ex[nex] = c[15:8]; ex_sum[nex] = 1; nex++;
            ex[nex] = c[7:0];  ex_sum[nex] = 1; nex++;
        end
        for (int i = npre + nsum; i < nw; i++) begin
            ex[nex] = wb[i]; ex_sum[nex] = 0; nex++;
        end
        frame_rate = rate;
        rate_sel   = rate;
        nrec       = 0;
        for (int k = 0; k < nw; k++) begin
            wait_empty();
            if (nsum > 0 && k == npre) sum_en = 1'b1;
            if (nsum > 0 && k == npre + nsum) sum_en = 1'b0;
            write_byte(wb[k]);
        end
        if (nsum > 0 && npost == 0) begin
            wait_empty();
            sum_en = 1'b0;
        end
        wait_frame_end();
        compare_stream();
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(buf_empty == 1'b1, "R1 buf_empty", buf_empty, 1);
        chk(phase_out == '0, "R1 phase", phase_out, 0);
        chk(tone_sel == 2'd0, "R1 tone", tone_sel, 0);
        rst_n = 1'b1;
        tx_en = 1'b1;
        @(negedge clk);

        // directed frames
        run_frame(2, 0, 0, 1'b0);
        run_frame(1, 3, 1, 1'b1);
        run_frame(0, 2, 0, 1'b0);
        run_frame(0, 1, 2, 1'b1);

        // R5: write into a full holding register is dropped
        frame_rate = 1'b0; rate_sel = 1'b0; nrec = 0;
        write_byte(8'hA5);
        wait_empty();
        write_byte(8'h3C);
        write_byte(8'hFF);
        chk(buf_empty == 1'b0, "R5 full flag", buf_empty, 0);
        wait_frame_end();
        nex = 2; ex[0] = 8'hA5; ex[1] = 8'h3C; ex_sum[0] = 0; ex_sum[1] = 0;
        compare_stream();

        // R9: receive enable aborts and blocks writes
        write_byte(8'h81);
        repeat (40) @(negedge clk);
        chk(busy == 1'b1, "R9 running before abort", busy, 1);
        rx_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R9 rx abort busy", busy, 0);
        chk(phase_out == '0, "R9 rx abort phase", phase_out, 0);
        write_byte(8'h55);
        chk(buf_empty == 1'b1, "R9 write ignored", buf_empty, 1);
        rx_en = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R9 nothing held", busy, 0);

        // R9: tone generator enable
        write_byte(8'h0F);
        write_byte(8'hF0);
        tone_en = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R9 tone abort busy", busy, 0);
        chk(buf_empty == 1'b1, "R9 tone abort buffer", buf_empty, 1);
        tone_en = 1'b0;

        // R9: transmit enable low
        tx_en = 1'b0;
        write_byte(8'h77);
        chk(buf_empty == 1'b1, "R9 tx off write", buf_empty, 1);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R9 tx off idle", busy, 0);
        tx_en = 1'b1;
        @(negedge clk);

        // random frames
        for (int f = 0; f < 6; f++) begin
            run_frame(int'($urandom_range(0, 2)), int'($urandom_range(0, 4)),
                      int'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule